// File: doc/BRIEF.md
# Modem Status and Interrupt Register

This block is the 16-bit read-only status word of a modem controller, reached over a plain address/strobe register bus. It gathers strobes and levels from the transmit data path, a ring detector, a programming engine and the receive detectors. It shows them in one word whose low eleven bits change meaning with the selected receive mode: tone detection, FSK, or QAM. A fourth, idle, mode shows nothing in those bits.

Most flags are sticky. Each flag is cleared by its own bus access: a status read, a write to the transmit data address, a write to the programming address, or a read of the QAM status address. The FSK bits are live copies of detector levels. A soft clear request clears bits 13 to 0, and a change of receive mode clears all of the receive-side state. A 7-bit mask register selects which flag groups drive the interrupt output. The same value is reported in bit 15. Bus reads are registered, so read data appears one cycle after the read strobe and shows the word as it was before that read's own clearing.

Top module: `mstat_reg`

## Requirements
- R1: After hardware reset, a status read returns 0x0000, a mask read returns 0x0000 and `irq` is 0.
- R2: Bit 12 sets on `txrdy_ev` and bit 11 sets on `txund_ev`. A bus write to the transmit data address (0x31) clears both.
- R3: When a set strobe and a clearing access for the same flag fall in one cycle, the flag ends up set.
- R4: A cycle with `soft_clr` high clears bits 13 to 0, even against a set strobe in that cycle. Bit 14 is kept.
- R5: Bit 14 sets on `ring_ev` and clears on a status read (address 0x30). That read still returns it as 1.
- R6: Bit 13 sets on `prog_ev`. A write to the programming address (0x34) clears it. A status read does not clear it.
- R7: In tone mode (`rx_mode`=0), the bits are as follows. Bit 10 sets on `cp_ev`, or on `tone1_ev` and `tone2_ev` together. Bit 7 sets on `tone2_ev`, bit 6 on `tone1_ev` and bit 5 on `dtmf_ev`. Bits 3-0 load `dtmf_code` on `dtmf_ev` and survive status reads. Bits 9, 8 and 4 read 0. A status read clears bits 10, 7, 6 and 5.
- R8: In FSK mode (`rx_mode`=1), bits 10, 9, 8 and 7 show `fsk_lvl[3]`, `[2]`, `[1]` and `[0]` live. Bits 6-0 read 0, and no strobe is recorded.
- R9: In QAM mode (`rx_mode`=2), bit 9 sets on `qam_ev` and clears only on a read of address 0x32. Bit 8 sets on `brk_ev` and clears on a status read. The other bits in 10-0 read 0.
- R10: Any change of `rx_mode` clears all stored state in bits 10-0, including the DTMF code.
- R11: A write to address 0x33 loads mask bits 6-0, and a read of 0x33 returns them. Each mask bit enables one source. Mask bits 0, 1, 2 and 3 enable status bits 14, 13, 12 and 11. Mask bit 4 enables bit 10. Mask bit 5 enables any of bits 9-7, and mask bit 6 enables either of bits 6-5. `irq` is the OR of the enabled sources, and a status read returns it in bit 15.
- R12: Read data updates on the clock edge after a read strobe. Reads of any address other than 0x30 and 0x33 return 0x0000, and that includes 0x32.
- R13: In idle mode (`rx_mode`=3), bits 10-0 read 0 and receive strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_addr | input | ADDR_W (8) | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| soft_clr | input | 1 | Soft clear request for bits 13-0 |
| rx_mode | input | 2 | Receive mode: 0 tone, 1 FSK, 2 QAM, 3 idle |
| ring_ev | input | 1 | Ring detected strobe |
| prog_ev | input | 1 | Programming flag strobe |
| txrdy_ev | input | 1 | Transmitter ready for data strobe |
| txund_ev | input | 1 | Transmit underflow strobe |
| cp_ev | input | 1 | Call-progress band energy strobe |
| tone1_ev | input | 1 | First answer/programmable tone strobe |
| tone2_ev | input | 1 | Second answer/programmable tone strobe |
| dtmf_ev | input | 1 | DTMF digit detected strobe |
| dtmf_code | input | 4 | DTMF digit code, valid with `dtmf_ev` |
| qam_ev | input | 1 | QAM modem event strobe |
| brk_ev | input | 1 | Start-stop break detected strobe |
| fsk_lvl | input | 4 | FSK levels: [3] energy, [2] alternating pattern, [1] steady zeros, [0] steady ones |
| irq | output | 1 | Active-high interrupt |

## Verification
A table sends single strobes and strobe pairs through each of the four receive modes. This shows whether the bit mapping follows the mode: the same `tone1_ev` is recorded in tone mode and ignored under QAM or idle, and the FSK level patterns 1010 and 0101 catch swapped bit lanes. Directed sequences place a set strobe in the same cycle as its clearing access or a soft clear. These sequences separate set-wins from clear-wins, and they separate the soft clear of bits 13 to 0 from the hardware reset. Back-to-back reads tell read-clear flags (ring, tones, break) from flags that need another access (programming, QAM event, DTMF code). Walking the mask over FSK levels shows that several status bits share one enable.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

  localparam int STAT_W = 16;
  localparam int RX_W   = 11;
  localparam int HI_W   = 4;
  localparam int MASK_W = 7;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    RXM_TONE = 2'b00,
    RXM_FSK  = 2'b01,
    RXM_QAM  = 2'b10,
    RXM_IDLE = 2'b11
  } rx_mode_e;

  typedef struct packed {
    logic rd_stat;
    logic rd_qam;
    logic rd_mask;
    logic wr_tx;
    logic wr_prog;
    logic wr_mask;
  } bus_ev_t;

  // Sticky set vector for bits 10..0 under the given mode (code bits excluded).
  function automatic logic [RX_W-1:0] rx_set_vec(
    input rx_mode_e m, input logic cp, input logic t1, input logic t2,
    input logic dtmf, input logic qam, input logic brk);
    logic [RX_W-1:0] s;
    s = '0;
    unique case (m)
      RXM_TONE: begin
        s[10] = cp | (t1 & t2);
        s[7]  = t2;
        s[6]  = t1;
        s[5]  = dtmf;
      end
      RXM_QAM: begin
        s[9] = qam;
        s[8] = brk;
      end
      default: s = '0;
    endcase
    return s;
  endfunction

  // Bits of 10..0 that carry stored meaning in each mode.
  function automatic logic [RX_W-1:0] rx_visible(input rx_mode_e m);
    unique case (m)
      RXM_TONE: return 11'b100_1110_1111;
      RXM_QAM:  return 11'b011_0000_0000;
      default:  return 11'b000_0000_0000;
    endcase
  endfunction

  // Stored bits cleared by a status read.
  localparam logic [RX_W-1:0] RX_RDCLR  = 11'b101_1110_0000;
  // Stored bit cleared by a QAM status read.
  localparam logic [RX_W-1:0] RX_QAMCLR = 11'b010_0000_0000;

  // Interrupt source groups, one per mask bit.
  function automatic logic [MASK_W-1:0] irq_sources(input logic [STAT_W-1:0] st);
    logic [MASK_W-1:0] g;
    g[0] = st[14];
    g[1] = st[13];
    g[2] = st[12];
    g[3] = st[11];
    g[4] = st[10];
    g[5] = |st[9:7];
    g[6] = |st[6:5];
    return g;
  endfunction

endpackage

// File: rtl/mstat_bus_dec.sv
module mstat_bus_dec
  import mstat_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] A_STAT  = 8'h30,
  parameter logic [ADDR_W-1:0] A_TXD   = 8'h31,
  parameter logic [ADDR_W-1:0] A_QAM   = 8'h32,
  parameter logic [ADDR_W-1:0] A_MASK  = 8'h33,
  parameter logic [ADDR_W-1:0] A_PROG  = 8'h34
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output bus_ev_t           ev_o
);
  always_comb begin
    ev_o.rd_stat = rd_i && (addr_i == A_STAT);
    ev_o.rd_qam  = rd_i && (addr_i == A_QAM);
    ev_o.rd_mask = rd_i && (addr_i == A_MASK);
    ev_o.wr_tx   = wr_i && (addr_i == A_TXD);
    ev_o.wr_prog = wr_i && (addr_i == A_PROG);
    ev_o.wr_mask = wr_i && (addr_i == A_MASK);
  end
endmodule

// File: rtl/mstat_tx_flags.sv
module mstat_tx_flags
  import mstat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_req,
  input  bus_ev_t         bev,
  input  logic            ring_ev,
  input  logic            prog_ev,
  input  logic            txrdy_ev,
  input  logic            txund_ev,
  output logic [HI_W-1:0] hi_o
);
  logic ring_q, prog_q, rdy_q, und_q;

  // Ring is outside the soft-clear range; only hardware reset and status read touch it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= 1'b0;
    else        ring_q <= (ring_q & ~bev.rd_stat) | ring_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= 1'b0;
      rdy_q  <= 1'b0;
      und_q  <= 1'b0;
    end else if (clr_req) begin
      prog_q <= 1'b0;
      rdy_q  <= 1'b0;
      und_q  <= 1'b0;
    end else begin
      prog_q <= (prog_q & ~bev.wr_prog) | prog_ev;
      rdy_q  <= (rdy_q  & ~bev.wr_tx)   | txrdy_ev;
      und_q  <= (und_q  & ~bev.wr_tx)   | txund_ev;
    end
  end

  assign hi_o = {ring_q, prog_q, rdy_q, und_q};

  assert_txrdy_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bev.wr_tx && !txrdy_ev) |=> !rdy_q);
  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (txund_ev && !clr_req) |=> und_q);
  assert_soft_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (!prog_q && !rdy_q && !und_q));
  assert_ring_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_q && !bev.rd_stat) |=> ring_q);
  assert_ring_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ring_ev |=> ring_q);
  assert_prog_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_q && !bev.wr_prog && !clr_req) |=> prog_q);
endmodule

// File: rtl/mstat_rx_flags.sv
module mstat_rx_flags
  import mstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_req,
  input  bus_ev_t           bev,
  input  logic [1:0]        mode_i,
  input  logic              cp_ev,
  input  logic              tone1_ev,
  input  logic              tone2_ev,
  input  logic              dtmf_ev,
  input  logic [CODE_W-1:0] dtmf_code,
  input  logic              qam_ev,
  input  logic              brk_ev,
  input  logic [3:0]        fsk_lvl,
  output logic [RX_W-1:0]   rx_o,
  output logic              mode_chg_o
);
  rx_mode_e        mode, mode_q;
  logic [RX_W-1:0] st_q, st_d, set_v, clr_v;
  logic            code_ld, any_set;

  assign mode       = rx_mode_e'(mode_i);
  assign mode_chg_o = (mode != mode_q);
  assign set_v      = rx_set_vec(mode, cp_ev, tone1_ev, tone2_ev, dtmf_ev, qam_ev, brk_ev);
  assign code_ld    = dtmf_ev && (mode == RXM_TONE);
  assign any_set    = (|set_v) || code_ld;

  always_comb begin
    clr_v = '0;
    if (bev.rd_stat) clr_v = clr_v | RX_RDCLR;
    if (bev.rd_qam)  clr_v = clr_v | RX_QAMCLR;
    if (mode_chg_o)  clr_v = '1;
  end

  always_comb begin
    st_d = (st_q & ~clr_v) | set_v;
    if (code_ld) st_d[CODE_W-1:0] = dtmf_code;
    if (clr_req) st_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      mode_q <= RXM_TONE;
    end else begin
      st_q   <= st_d;
      mode_q <= mode;
    end
  end

  always_comb begin
    if (mode == RXM_FSK) rx_o = {fsk_lvl & {4{~clr_req}}, 7'b0};
    else                 rx_o = st_q & rx_visible(mode);
  end

  assert_tone_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RXM_TONE && tone1_ev && !clr_req) |=> st_q[6]);
  assert_fsk_nostore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RXM_FSK && !mode_chg_o) |-> (st_q == '0));
  assert_qam_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bev.rd_qam && !set_v[9]) |=> !st_q[9]);
  assert_mode_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg_o && !any_set) |=> (st_q == '0));
  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RXM_IDLE) |-> (rx_o == '0));
endmodule

// File: rtl/mstat_irq.sv
module mstat_irq
  import mstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ev_t           bev,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [MASK_W-1:0] mask_o,
  output logic              irq_o
);
  logic [MASK_W-1:0] mask_q, src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mask_q <= '0;
    else if (bev.wr_mask) mask_q <= wdata_i[MASK_W-1:0];
  end

  assign src    = irq_sources(stat_i);
  assign irq_o  = |(src & mask_q);
  assign mask_o = mask_q;

  assert_mask_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);
  assert_mask_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bev.wr_mask |=> (mask_q == $past(wdata_i[MASK_W-1:0])));
endmodule

// File: rtl/mstat_reg.sv
module mstat_reg
  import mstat_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_STAT = 8'h30,
  parameter logic [ADDR_W-1:0] A_TXD  = 8'h31,
  parameter logic [ADDR_W-1:0] A_QAM  = 8'h32,
  parameter logic [ADDR_W-1:0] A_MASK = 8'h33,
  parameter logic [ADDR_W-1:0] A_PROG = 8'h34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              soft_clr,
  input  logic [1:0]        rx_mode,
  input  logic              ring_ev,
  input  logic              prog_ev,
  input  logic              txrdy_ev,
  input  logic              txund_ev,
  input  logic              cp_ev,
  input  logic              tone1_ev,
  input  logic              tone2_ev,
  input  logic              dtmf_ev,
  input  logic [3:0]        dtmf_code,
  input  logic              qam_ev,
  input  logic              brk_ev,
  input  logic [3:0]        fsk_lvl,
  output logic              irq
);
  bus_ev_t           bev;
  logic [HI_W-1:0]   hi_bits;
  logic [RX_W-1:0]   rx_bits;
  logic [STAT_W-1:0] stat_raw;
  logic [MASK_W-1:0] mask_val;
  logic              irq_w, mode_chg;
  logic [15:0]       rdata_q;

  mstat_bus_dec #(
    .ADDR_W(ADDR_W), .A_STAT(A_STAT), .A_TXD(A_TXD),
    .A_QAM(A_QAM), .A_MASK(A_MASK), .A_PROG(A_PROG)
  ) u_dec (
    .addr_i(bus_addr), .rd_i(bus_rd), .wr_i(bus_wr), .ev_o(bev)
  );

  mstat_tx_flags u_tx (
    .clk(clk), .rst_n(rst_n), .clr_req(soft_clr), .bev(bev),
    .ring_ev(ring_ev), .prog_ev(prog_ev), .txrdy_ev(txrdy_ev),
    .txund_ev(txund_ev), .hi_o(hi_bits)
  );

  mstat_rx_flags u_rx (
    .clk(clk), .rst_n(rst_n), .clr_req(soft_clr), .bev(bev),
    .mode_i(rx_mode), .cp_ev(cp_ev), .tone1_ev(tone1_ev),
    .tone2_ev(tone2_ev), .dtmf_ev(dtmf_ev), .dtmf_code(dtmf_code),
    .qam_ev(qam_ev), .brk_ev(brk_ev), .fsk_lvl(fsk_lvl),
    .rx_o(rx_bits), .mode_chg_o(mode_chg)
  );

  assign stat_raw = {1'b0, hi_bits, rx_bits};

  mstat_irq u_irq (
    .clk(clk), .rst_n(rst_n), .bev(bev), .wdata_i(bus_wdata),
    .stat_i(stat_raw), .mask_o(mask_val), .irq_o(irq_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (bus_rd) begin
      if (bev.rd_stat)      rdata_q <= {irq_w, stat_raw[14:0]};
      else if (bev.rd_mask) rdata_q <= {{(16-MASK_W){1'b0}}, mask_val};
      else                  rdata_q <= '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_w;

  assert_read_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bev.rd_stat |=> (bus_rdata[15] == $past(irq_w)));
  assert_read_other_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bev.rd_stat && !bev.rd_mask) |=> (bus_rdata == 16'h0000));
  assert_read_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bev.rd_stat && hi_bits[3]) |=> bus_rdata[14]);
endmodule

// File: tb/mstat_reg_tb.sv
module mstat_reg_tb_top;
  localparam logic [7:0] A_STAT = 8'h30, A_TXD = 8'h31, A_QAM = 8'h32,
                         A_MASK = 8'h33, A_PROG = 8'h34;
  // event order: 9 ring,8 prog,7 txrdy,6 txund,5 cp,4 tone1,3 tone2,2 dtmf,1 qam,0 brk
  // vector: [35:34] mode, [33:24] events, [23:20] fsk, [19:16] code, [15:0] expected
  localparam int NV = 13;
  localparam logic [35:0] VEC [NV] = '{
    {2'd0, 10'b0000100000, 4'h0, 4'h0, 16'h0400},  // R7 call progress
    {2'd0, 10'b0000011000, 4'h0, 4'h0, 16'h04C0},  // R7 both tones
    {2'd0, 10'b0000010000, 4'h0, 4'h0, 16'h0040},  // R7 first tone
    {2'd0, 10'b1000000000, 4'h0, 4'h0, 16'h4000},  // R5 ring
    {2'd0, 10'b0111000000, 4'h0, 4'h0, 16'h3800},  // R2/R6
    {2'd0, 10'b0000000100, 4'h0, 4'h5, 16'h0025},  // R7 dtmf
    {2'd1, 10'b0000000000, 4'hA, 4'h0, 16'h0500},  // R8 1010
    {2'd1, 10'b0000000000, 4'h5, 4'h0, 16'h0280},  // R8 0101
    {2'd1, 10'b0000111111, 4'h0, 4'h0, 16'h0000},  // R8 strobes ignored
    {2'd2, 10'b0000000010, 4'h0, 4'h0, 16'h0200},  // R9 qam event
    {2'd2, 10'b0000000001, 4'h0, 4'h0, 16'h0100},  // R9 break
    {2'd2, 10'b0000110100, 4'h0, 4'h0, 16'h0000},  // R9 tone strobes ignored
    {2'd3, 10'b0000111111, 4'h0, 4'h0, 16'h0000}   // R13 idle
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_rd = 0, bus_wr = 0, soft_clr = 0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [1:0] rx_mode = 2'd0;
  logic [9:0] ev = '0;
  logic [3:0] dtmf_code = '0, fsk_lvl = '0;
  logic irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mstat_reg dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .soft_clr(soft_clr), .rx_mode(rx_mode), .ring_ev(ev[9]), .prog_ev(ev[8]),
    .txrdy_ev(ev[7]), .txund_ev(ev[6]), .cp_ev(ev[5]), .tone1_ev(ev[4]),
    .tone2_ev(ev[3]), .dtmf_ev(ev[2]), .dtmf_code(dtmf_code), .qam_ev(ev[1]),
    .brk_ev(ev[0]), .fsk_lvl(fsk_lvl), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input logic [9:0] e);
    ev = e;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    rx_mode = m;
    @(negedge clk);
  endtask

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'd0: return "R7 table";
      2'd1: return "R8 table";
      2'd2: return "R9 table";
      default: return "R13 table";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_STAT, d); check("R1 status", d, 16'h0000);
    rd(A_MASK, d); check("R1 mask", d, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      set_mode(VEC[i][35:34]);
      fsk_lvl   = VEC[i][23:20];
      dtmf_code = VEC[i][19:16];
      pulse(VEC[i][33:24]);
      rd(A_STAT, d);
      check(tag_of(VEC[i][35:34]), d, VEC[i][15:0]);
      fsk_lvl = '0;
      rd(A_STAT, d);
      wr(A_TXD, 16'h0);
      wr(A_PROG, 16'h0);
      rd(A_QAM, d);
    end

    // R2 transmit flags clear on Tx data write
    set_mode(2'd0);
    pulse(10'b0010000000);
    rd(A_STAT, d); check("R2 ready set", d, 16'h1000);
    wr(A_TXD, 16'h0);
    rd(A_STAT, d); check("R2 ready clear", d, 16'h0000);
    pulse(10'b0001000000);
    wr(A_TXD, 16'h0);
    rd(A_STAT, d); check("R2 underflow clear", d, 16'h0000);

    // R3 set wins against clearing access
    ev = 10'b0010000000; bus_addr = A_TXD; bus_wr = 1'b1;
    @(negedge clk);
    ev = '0; bus_wr = 1'b0;
    rd(A_STAT, d); check("R3 ready vs write", d, 16'h1000);
    wr(A_TXD, 16'h0);
    ev = 10'b1000000000; bus_addr = A_STAT; bus_rd = 1'b1;
    @(negedge clk);
    ev = '0; bus_rd = 1'b0;
    rd(A_STAT, d); check("R3 ring vs read", d, 16'h4000);

    // R5 ring clears on status read
    pulse(10'b1000000000);
    rd(A_STAT, d); check("R5 ring read", d, 16'h4000);
    rd(A_STAT, d); check("R5 ring cleared", d, 16'h0000);

    // R6 programming flag
    pulse(10'b0100000000);
    rd(A_STAT, d); check("R6 prog set", d, 16'h2000);
    rd(A_STAT, d); check("R6 prog kept by read", d, 16'h2000);
    wr(A_PROG, 16'h0);
    rd(A_STAT, d); check("R6 prog clear", d, 16'h0000);

    // R7 DTMF code survives status read
    dtmf_code = 4'hA;
    pulse(10'b0000000100);
    rd(A_STAT, d); check("R7 dtmf first read", d, 16'h002A);
    rd(A_STAT, d); check("R7 dtmf code kept", d, 16'h000A);

    // R10 mode change clears stored state
    pulse(10'b0000100000);
    set_mode(2'd2);
    set_mode(2'd0);
    rd(A_STAT, d); check("R10 mode change clear", d, 16'h0000);

    // R9 QAM event clears only through QAM status read
    set_mode(2'd2);
    pulse(10'b0000000010);
    rd(A_STAT, d); check("R9 qam set", d, 16'h0200);
    rd(A_STAT, d); check("R9 qam kept by status read", d, 16'h0200);
    rd(A_QAM, d);  check("R12 qam address reads zero", d, 16'h0000);
    rd(A_STAT, d); check("R9 qam cleared", d, 16'h0000);

    // R4 soft clear keeps ring, beats a same-cycle set
    set_mode(2'd0);
    pulse(10'b1110100000);
    ev = 10'b0001000000; soft_clr = 1'b1;
    @(negedge clk);
    ev = '0; soft_clr = 1'b0;
    rd(A_STAT, d); check("R4 soft clear", d, 16'h4000);
    rd(A_STAT, d);

    // R11 mask and interrupt
    wr(A_MASK, 16'hFF81);
    rd(A_MASK, d); check("R11 mask readback", d, 16'h0001);
    pulse(10'b1000000000);
    check("R11 irq ring", {15'd0, irq}, 16'h0001);
    rd(A_STAT, d); check("R11 bit15", d, 16'hC000);
    check("R11 irq after read", {15'd0, irq}, 16'h0000);
    wr(A_MASK, 16'h0020);
    set_mode(2'd1);
    fsk_lvl = 4'b0001; @(negedge clk);
    check("R11 shared mask bit7", {15'd0, irq}, 16'h0001);
    fsk_lvl = 4'b0100; @(negedge clk);
    check("R11 shared mask bit9", {15'd0, irq}, 16'h0001);
    fsk_lvl = 4'b1000; @(negedge clk);
    check("R11 bit10 not in group", {15'd0, irq}, 16'h0000);
    fsk_lvl = 4'b0000;
    wr(A_MASK, 16'h0000);

    // R12 unmapped address
    rd(8'h55, d); check("R12 unmapped read", d, 16'h0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule